// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This unit turns one of three 16-bit data pointers into an effective data-space address for a load or store. Each pointer is a pair of adjacent general registers (low byte in the even register, high byte in the odd one). The surrounding pipeline reads the two bytes, presents them with a pointer select, an addressing operation and a small displacement, and one cycle later receives the effective address, the region that address falls in, a region-local offset, and, for the auto-modifying operations, the new pointer value with the register index it belongs to.

Five operations are supported. Plain indirect uses the pointer as is. Post-increment addresses with the old value and returns the value plus one. Pre-decrement subtracts one first, addresses with the result and returns it. Displacement adds an unsigned offset without touching the pointer and is legal for the second and third pointers only. Table lookup, legal on the third pointer only, passes the pointer through as a program-memory byte address. Data addresses are classified into the register-file window, the I/O window, the SRAM window, or beyond the end of SRAM.

Top module: `ptr_agu`

## Requirements
- R1: While reset is high and on the first cycle after it, `vld`, `wb_en`, every `hit_*` output, `oor` and `illegal` are 0.
- R2: A request (`req`=1) produces its results exactly one clock later with `vld`=1; op code 0 (plain) gives `ea` equal to the pointer and `wb_en`=0.
- R3: Op code 1 (post-increment) gives `ea` equal to the pointer and `wb_val` equal to pointer+1 with `wb_en`=1; 0xFFFF returns 0x0000.
- R4: Op code 2 (pre-decrement) gives `ea` and `wb_val` both equal to pointer-1 with `wb_en`=1; 0x0000 gives 0xFFFF.
- R5: Op code 3 (displacement) on pointer select 1 or 2 gives `ea` equal to pointer plus `disp` zero-extended, modulo 2^16, with `wb_en`=0.
- R6: Op code 3 on pointer select 0 sets `illegal`=1 with `wb_en`=0 and no `hit_*` or `oor`.
- R7: Op code 4 (table lookup) on pointer select 2 sets `hit_prog`=1 with `ea` equal to the pointer and `wb_en`=0; on any other select, and for op codes 5 to 7, `illegal`=1 instead.
- R8: A legal data access with `ea` below 0x20 sets `hit_rf`=1 and `loc`=`ea`.
- R9: A legal data access with `ea` in 0x20..0x5F sets `hit_io`=1 and `loc`=`ea`-0x20.
- R10: A legal data access with `ea` in 0x60..0x60+SRAM_BYTES-1 sets `hit_sram`=1 and `loc`=`ea`-0x60.
- R11: A legal data access at or above 0x60+SRAM_BYTES sets `oor`=1 only; when `vld`=1 exactly one of the hit outputs, `oor` and `illegal` is 1.
- R12: Pointer select 0, 1, 2 picks register pairs 26/27, 28/29, 30/31 and `wb_reg` reports the low index 26, 28 or 30; select 3 sets `illegal`=1.
- R13: A cycle with `req`=0 gives `vld`=0 and all strobes 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Address request this cycle |
| ptr_sel | input | 2 | Pointer select: 0, 1, 2, or 3 (none) |
| op | input | 3 | Operation: 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 table |
| disp | input | DISP_W | Unsigned displacement |
| ptr_lo | input | 8 | Pointer low byte from the even register |
| ptr_hi | input | 8 | Pointer high byte from the odd register |
| vld | output | 1 | Result valid |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back required |
| wb_reg | output | 5 | Low register index of the pointer to write back |
| wb_val | output | 16 | New pointer value |
| hit_rf | output | 1 | Address in register-file window |
| hit_io | output | 1 | Address in I/O window |
| hit_sram | output | 1 | Address in SRAM window |
| hit_prog | output | 1 | Program-memory table access |
| oor | output | 1 | Data address beyond SRAM |
| illegal | output | 1 | Pointer/operation combination not allowed |
| loc | output | LOC_W | Offset within the hit window |

## Verification
The bench targets the wrap points of the pointer arithmetic (increment from 0xFFFF, decrement from 0x0000, displacement past 0xFFFF); an adder with the wrong operand or ordering returns the pre-decrement address as the old value or leaks a carry into the region decode. It walks the edges of each window (0x1F/0x20, 0x5F/0x60, the last SRAM byte and the first byte past it), where an off-by-one compare would raise two strobes or the wrong offset. Displacement on the first pointer, table lookup away from the third, select 3 and unused op codes must all yield `illegal` with no write-back; a design that forgot a restriction would quietly produce an address and corrupt a pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_POSTINC = 3'd1,
        OP_PREDEC  = 3'd2,
        OP_DISP    = 3'd3,
        OP_TABLE   = 3'd4
    } agu_op_e;

    typedef enum logic [1:0] {
        PSEL_X    = 2'd0,
        PSEL_Y    = 2'd1,
        PSEL_Z    = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_RF   = 3'd1,
        RGN_IO   = 3'd2,
        RGN_SRAM = 3'd3,
        RGN_PROG = 3'd4,
        RGN_OOR  = 3'd5
    } region_e;

    // Window bases in data space
    localparam logic [15:0] IO_BASE   = 16'h0020;
    localparam logic [15:0] SRAM_BASE = 16'h0060;
    localparam int          ADDR_W    = 16;

    // Low register index of each pointer pair (R12)
    function automatic logic [4:0] pair_low_reg(ptr_sel_e s);
        case (s)
            PSEL_X:  return 5'd26;
            PSEL_Y:  return 5'd28;
            PSEL_Z:  return 5'd30;
            default: return 5'd0;
        endcase
    endfunction

    // Which pointer/operation pairs are allowed (R6, R7, R12)
    function automatic logic op_allowed(agu_op_e o, ptr_sel_e s);
        if (s == PSEL_NONE) return 1'b0;
        case (o)
            OP_PLAIN, OP_POSTINC, OP_PREDEC: return 1'b1;
            OP_DISP:  return (s != PSEL_X);
            OP_TABLE: return (s == PSEL_Z);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/agu_arith.sv
module agu_arith
    import agu_pkg::*;
#(
    parameter int DISP_W = 6
) (
    input  agu_op_e            op,
    input  logic [ADDR_W-1:0]  ptr,
    input  logic [DISP_W-1:0]  disp,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  nxt,
    output logic               modifies
);
    logic [ADDR_W-1:0] addend;
    logic [ADDR_W-1:0] sum;

    // One shared 16-bit adder; the operand picks the mode
    always_comb begin
        case (op)
            OP_POSTINC: addend = 16'h0001;
            OP_PREDEC:  addend = 16'hFFFF;
            OP_DISP:    addend = {{(ADDR_W-DISP_W){1'b0}}, disp};
            default:    addend = '0;
        endcase
    end

    assign sum = ptr + addend;

    always_comb begin
        case (op)
            OP_PREDEC, OP_DISP: ea = sum;
            default:            ea = ptr;
        endcase
        nxt      = sum;
        modifies = (op == OP_POSTINC) || (op == OP_PREDEC);
    end

endmodule

// File: rtl/agu_region.sv
module agu_region
    import agu_pkg::*;
#(
    parameter int SRAM_BYTES = 512,
    parameter int LOC_W      = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              legal,
    input  logic              is_table,
    output region_e           rgn,
    output logic [LOC_W-1:0]  loc
);
    localparam int SRAM_END = int'(SRAM_BASE) + SRAM_BYTES;

    always_comb begin
        rgn = RGN_NONE;
        loc = '0;
        if (!legal) begin
            rgn = RGN_NONE;
        end else if (is_table) begin
            rgn = RGN_PROG;
        end else if (addr < IO_BASE) begin
            rgn = RGN_RF;
            loc = LOC_W'(addr);
        end else if (addr < SRAM_BASE) begin
            rgn = RGN_IO;
            loc = LOC_W'(addr - IO_BASE);
        end else if (int'(addr) < SRAM_END) begin
            rgn = RGN_SRAM;
            loc = LOC_W'(addr - SRAM_BASE);
        end else begin
            rgn = RGN_OOR;
        end
    end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import agu_pkg::*;
#(
    parameter int  SRAM_BYTES = 512,
    parameter int  DISP_W     = 6,
    localparam int LOC_W      = ($clog2(SRAM_BYTES) > 6) ? $clog2(SRAM_BYTES) : 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        ptr_sel,
    input  logic [2:0]        op,
    input  logic [DISP_W-1:0] disp,
    input  logic [7:0]        ptr_lo,
    input  logic [7:0]        ptr_hi,
    output logic              vld,
    output logic [15:0]       ea,
    output logic              wb_en,
    output logic [4:0]        wb_reg,
    output logic [15:0]       wb_val,
    output logic              hit_rf,
    output logic              hit_io,
    output logic              hit_sram,
    output logic              hit_prog,
    output logic              oor,
    output logic              illegal,
    output logic [LOC_W-1:0]  loc
);
    agu_op_e           op_e;
    ptr_sel_e          sel_e;
    logic              legal;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ea_c, nxt_c;
    logic              mod_c;
    region_e           rgn_c;
    logic [LOC_W-1:0]  loc_c;

    assign op_e  = agu_op_e'(op);
    assign sel_e = ptr_sel_e'(ptr_sel);
    assign legal = op_allowed(op_e, sel_e);
    assign ptr   = {ptr_hi, ptr_lo};

    agu_arith #(.DISP_W(DISP_W)) u_arith (
        .op       (op_e),
        .ptr      (ptr),
        .disp     (disp),
        .ea       (ea_c),
        .nxt      (nxt_c),
        .modifies (mod_c)
    );

    agu_region #(.SRAM_BYTES(SRAM_BYTES), .LOC_W(LOC_W)) u_region (
        .addr     (ea_c),
        .legal    (legal),
        .is_table (op_e == OP_TABLE),
        .rgn      (rgn_c),
        .loc      (loc_c)
    );

    // Result stage
    logic              vld_q, wb_en_q, ill_q;
    logic [ADDR_W-1:0] ea_q, wb_val_q;
    logic [4:0]        wb_reg_q;
    region_e           rgn_q;
    logic [LOC_W-1:0]  loc_q;
    agu_op_e           op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            wb_en_q  <= 1'b0;
            ill_q    <= 1'b0;
            ea_q     <= '0;
            wb_val_q <= '0;
            wb_reg_q <= '0;
            rgn_q    <= RGN_NONE;
            loc_q    <= '0;
            op_q     <= OP_PLAIN;
        end else begin
            vld_q    <= req;
            wb_en_q  <= req && legal && mod_c;
            ill_q    <= req && !legal;
            ea_q     <= ea_c;
            wb_val_q <= nxt_c;
            wb_reg_q <= pair_low_reg(sel_e);
            rgn_q    <= req ? rgn_c : RGN_NONE;
            loc_q    <= loc_c;
            op_q     <= op_e;
        end
    end

    assign vld      = vld_q;
    assign ea       = ea_q;
    assign wb_en    = wb_en_q;
    assign wb_reg   = wb_reg_q;
    assign wb_val   = wb_val_q;
    assign hit_rf   = (rgn_q == RGN_RF);
    assign hit_io   = (rgn_q == RGN_IO);
    assign hit_sram = (rgn_q == RGN_SRAM);
    assign hit_prog = (rgn_q == RGN_PROG);
    assign oor      = (rgn_q == RGN_OOR);
    assign illegal  = ill_q;
    assign loc      = loc_q;

    // Checks on the result stage
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !vld |-> !(wb_en || hit_rf || hit_io || hit_sram || hit_prog || oor || illegal));

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
        vld |-> $countones({hit_rf, hit_io, hit_sram, hit_prog, oor, illegal}) == 1);

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(req));

    a_r3_postinc_next: assert property (@(posedge clk) disable iff (rst)
        (vld && !illegal && op_q == OP_POSTINC) |-> (wb_en && wb_val == ea + 16'd1));

    a_r4_predec_same: assert property (@(posedge clk) disable iff (rst)
        (vld && !illegal && op_q == OP_PREDEC) |-> (wb_en && wb_val == ea));

    a_r5_disp_keeps: assert property (@(posedge clk) disable iff (rst)
        (vld && op_q == OP_DISP) |-> !wb_en);

    a_r6_illegal_inert: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wb_en);

endmodule

// File: tb/ptr_agu_test.sv
module ptr_agu_test;
    localparam int SRAM_BYTES = 512;
    localparam int DISP_W     = 6;
    localparam int LOC_W      = 9;

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic [1:0]        ptr_sel;
    logic [2:0]        op;
    logic [DISP_W-1:0] disp;
    logic [7:0]        ptr_lo, ptr_hi;
    logic              vld, wb_en, hit_rf, hit_io, hit_sram, hit_prog, oor, illegal;
    logic [15:0]       ea, wb_val;
    logic [4:0]        wb_reg;
    logic [LOC_W-1:0]  loc;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ptr_agu #(.SRAM_BYTES(SRAM_BYTES), .DISP_W(DISP_W)) uut (
        .clk(clk), .rst(rst), .req(req), .ptr_sel(ptr_sel), .op(op), .disp(disp),
        .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .vld(vld), .ea(ea), .wb_en(wb_en),
        .wb_reg(wb_reg), .wb_val(wb_val), .hit_rf(hit_rf), .hit_io(hit_io),
        .hit_sram(hit_sram), .hit_prog(hit_prog), .oor(oor), .illegal(illegal),
        .loc(loc)
    );

    // outcome code: 0 none, 1 rf, 2 io, 3 sram, 4 prog, 5 oor, 6 illegal, 9 several
    function automatic int outcome();
        int n = hit_rf + hit_io + hit_sram + hit_prog + oor + illegal;
        if (n > 1) return 9;
        if (hit_rf)   return 1;
        if (hit_io)   return 2;
        if (hit_sram) return 3;
        if (hit_prog) return 4;
        if (oor)      return 5;
        if (illegal)  return 6;
        return 0;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Issue one request, then look at the result one clock later
    task automatic issue(input int sel, input int o, input int d, input int p);
        @(negedge clk);
        req = 1'b1; ptr_sel = 2'(sel); op = 3'(o); disp = DISP_W'(d);
        ptr_lo = p[7:0]; ptr_hi = p[15:8];
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic expect_res(string tag, int exp_out, int exp_ea, int exp_loc,
                              int exp_wb, int exp_wbv, int exp_wbr);
        cmp(tag, "vld", vld, 1);
        cmp(tag, "outcome", outcome(), exp_out);
        cmp(tag, "wb_en", wb_en, exp_wb);
        if (exp_out != 6) cmp(tag, "ea", ea, exp_ea);
        if (exp_out >= 1 && exp_out <= 3) cmp(tag, "loc", loc, exp_loc);
        if (exp_wb != 0) begin
            cmp(tag, "wb_val", wb_val, exp_wbv);
            cmp(tag, "wb_reg", wb_reg, exp_wbr);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b0; ptr_sel = '0; op = '0; disp = '0; ptr_lo = '0; ptr_hi = '0;
        repeat (3) @(negedge clk);
        cmp("R1", "vld in reset", vld, 0);
        cmp("R1", "strobes in reset", outcome() + wb_en, 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1", "vld after reset", vld, 0);
        cmp("R1", "strobes after reset", outcome() + wb_en, 0);
    endtask

    task automatic t_plain();
        issue(0, 0, 0, 16'h0105); expect_res("R2 R10", 3, 16'h0105, 16'h00A5, 0, 0, 0);
        issue(0, 0, 0, 16'h001F); expect_res("R2 R8", 1, 16'h001F, 31, 0, 0, 0);
        issue(1, 0, 0, 16'h005F); expect_res("R2 R9", 2, 16'h005F, 16'h003F, 0, 0, 0);
    endtask

    task automatic t_postinc();
        issue(1, 1, 0, 16'h003F); expect_res("R3 R12", 2, 16'h003F, 16'h001F, 1, 16'h0040, 28);
        issue(2, 1, 0, 16'hFFFF); expect_res("R3 R11", 5, 16'hFFFF, 0, 1, 16'h0000, 30);
    endtask

    task automatic t_predec();
        issue(0, 2, 0, 16'h0000); expect_res("R4 R12", 5, 16'hFFFF, 0, 1, 16'hFFFF, 26);
        issue(2, 2, 0, 16'h0021); expect_res("R4 R9", 2, 16'h0020, 0, 1, 16'h0020, 30);
        issue(1, 2, 0, 16'h0060); expect_res("R4 R9", 2, 16'h005F, 16'h003F, 1, 16'h005F, 28);
    endtask

    task automatic t_disp();
        issue(1, 3, 63, 16'h0010); expect_res("R5", 2, 16'h004F, 16'h002F, 0, 0, 0);
        issue(2, 3, 16'h20, 16'hFFF0); expect_res("R5 R8", 1, 16'h0010, 16'h0010, 0, 0, 0);
        issue(0, 3, 5, 16'h0100); expect_res("R6", 6, 0, 0, 0, 0, 0);
    endtask

    task automatic t_table();
        issue(2, 4, 0, 16'h1234); expect_res("R7", 4, 16'h1234, 0, 0, 0, 0);
        issue(1, 4, 0, 16'h1234); expect_res("R7", 6, 0, 0, 0, 0, 0);
        issue(2, 5, 0, 16'h0040); expect_res("R7", 6, 0, 0, 0, 0, 0);
        issue(3, 0, 0, 16'h0040); expect_res("R12", 6, 0, 0, 0, 0, 0);
    endtask

    task automatic t_sram_edges();
        issue(0, 0, 0, 16'h0060); expect_res("R10", 3, 16'h0060, 0, 0, 0, 0);
        issue(0, 0, 0, 16'h025F); expect_res("R10", 3, 16'h025F, 16'h01FF, 0, 0, 0);
        issue(0, 0, 0, 16'h0260); expect_res("R11", 5, 16'h0260, 0, 0, 0, 0);
    endtask

    task automatic t_idle();
        issue(1, 1, 0, 16'h0200);
        expect_res("R13 R3", 3, 16'h0200, 16'h01A0, 1, 16'h0201, 28);
        @(negedge clk);
        cmp("R13", "vld idle", vld, 0);
        cmp("R13", "strobes idle", outcome() + wb_en, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_table();
        t_sram_edges();
        t_idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule